// File: doc/BRIEF.md
# USB Device Interrupt Status Tree

This block gathers the interrupt events of a USB device controller into a two-level tree and drives a single interrupt line. Events arrive as one-cycle pulses and fall into three groups. Group 0 holds control-endpoint events, group 1 holds the per-FIFO receive-ready events, and group 2 holds device-status events. Each group has a sticky status register and its own mask. A summary register shows, for each group, whether that group has any unmasked pending event. A separate group mask can hide each summary bit.

Any unmasked summary bit sets a sticky device bit in the top-level status register. That bit has its own mask. A polarity bit selects whether the output is asserted high or low. A global enable in the control register gates the output, and the output stays low while the enable is clear. Software reads and writes the registers through a simple 32-bit port: writes take effect on the clock edge, and reads are combinational.

A set mask bit disables its source. All status bits clear when software writes one to them. Writing zero to a status bit leaves it unchanged.

Top module: `usb_irq_tree`

## Requirements
- R1: After reset, every status register reads zero and `irq_o` is low. The control register reads 0. The masks read all ones: group 0 mask 0x3F, group 1 mask 0xF, group 2 mask 0x7FF, group mask 0x7 and top mask 0x3.
- R2: An event pulse on bit i of `ev_ctl` (word 5), `ev_rx` (word 7) or `ev_dev` (word 9) sets bit i of that group's status register. The bit can be read after the next clock edge and stays set until it is cleared.
- R3: Writing a status register clears exactly the bits written as one. A write of zero changes no bit.
- R4: If an event pulse and a write-one-clear hit the same status bit in the same cycle, the bit stays set.
- R5: Summary register (word 3, read-only) bit g equals the OR of (status AND NOT mask) of group g. Group mask (word 4) bit g equal to 1 blocks summary bit g from reaching the top level.
- R6: Top status (word 1) bit 0 is set on the edge after any summary bit is unmasked by the group mask. A write of one clears the bit only while no unmasked summary bit remains.
- R7: Let p be top status bit 0 AND NOT top mask (word 2) bit 0. With the enable set, `irq_o` equals p when top mask bit 1 is 1 (active high) and equals NOT p when that bit is 0 (active low). The output therefore follows an event by two clock edges.
- R8: While control (word 0) bit 0 (the global enable) is clear, `irq_o` is low whatever the status and the polarity.
- R9: The mask registers and the control register read back the written value, truncated to their width. Writes to the summary register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at `addr` |
| ev_ctl | input | 6 | Control-endpoint event pulses |
| ev_rx | input | NUM_FIFO | Per-FIFO receive-ready pulses |
| ev_dev | input | 11 | Device-status event pulses |
| irq_o | output | 1 | Interrupt output |

## Verification
The results arrive at fixed times. A group status bit and the summary bit can be read one edge after the event pulse. The top device bit and `irq_o` follow one edge after that. Register writes are visible one edge after the strobe. The bench drives all stimulus on the falling edge and reads one falling edge after each stimulus, with one extra cycle wherever the top-level bit is involved. Every value is checked at the exact cycle it is due, never by polling. The sweeps pulse every event bit of every group and try all 16 mask patterns of the receive group.

// File: rtl/usb_irq_tree.sv
module usb_irq_tree #(
  parameter int NUM_FIFO = 4,
  parameter int AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                wr_en,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [5:0]          ev_ctl,
  input  logic [NUM_FIFO-1:0] ev_rx,
  input  logic [10:0]         ev_dev,
  output logic                irq_o
);
  localparam int W0 = 6;
  localparam int W1 = NUM_FIFO;
  localparam int W2 = 11;
  localparam int NG = 3;

  localparam logic [AW-1:0] A_CTRL    = AW'(0);
  localparam logic [AW-1:0] A_TOP_ST  = AW'(1);
  localparam logic [AW-1:0] A_TOP_MSK = AW'(2);
  localparam logic [AW-1:0] A_SUM     = AW'(3);
  localparam logic [AW-1:0] A_SUM_MSK = AW'(4);
  localparam logic [AW-1:0] A_G0_ST   = AW'(5);
  localparam logic [AW-1:0] A_G0_MSK  = AW'(6);
  localparam logic [AW-1:0] A_G1_ST   = AW'(7);
  localparam logic [AW-1:0] A_G1_MSK  = AW'(8);
  localparam logic [AW-1:0] A_G2_ST   = AW'(9);
  localparam logic [AW-1:0] A_G2_MSK  = AW'(10);

  logic          ctrl_en;
  logic          top_st;
  logic [1:0]    top_msk;
  logic [NG-1:0] sum_msk;
  logic [W0-1:0] g0_st, g0_msk;
  logic [W1-1:0] g1_st, g1_msk;
  logic [W2-1:0] g2_st, g2_msk;

  logic [NG-1:0] sum_raw, sum_pend;
  logic          top_pend;

  assign sum_raw  = {|(g2_st & ~g2_msk), |(g1_st & ~g1_msk), |(g0_st & ~g0_msk)};
  assign sum_pend = sum_raw & ~sum_msk;
  assign top_pend = top_st & ~top_msk[0];
  assign irq_o    = ctrl_en & (top_msk[1] ? top_pend : ~top_pend);

  function automatic logic wr_hit(input logic [AW-1:0] a);
    return wr_en && (addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      top_st  <= 1'b0;
      top_msk <= '1;
      sum_msk <= '1;
      g0_st   <= '0;
      g0_msk  <= '1;
      g1_st   <= '0;
      g1_msk  <= '1;
      g2_st   <= '0;
      g2_msk  <= '1;
    end else begin
      g0_st  <= (g0_st & ~(wr_hit(A_G0_ST) ? wdata[W0-1:0] : '0)) | ev_ctl;
      g1_st  <= (g1_st & ~(wr_hit(A_G1_ST) ? wdata[W1-1:0] : '0)) | ev_rx;
      g2_st  <= (g2_st & ~(wr_hit(A_G2_ST) ? wdata[W2-1:0] : '0)) | ev_dev;
      top_st <= (|sum_pend) | (top_st & ~(wr_hit(A_TOP_ST) & wdata[0]));
      if (wr_hit(A_CTRL))    ctrl_en <= wdata[0];
      if (wr_hit(A_TOP_MSK)) top_msk <= wdata[1:0];
      if (wr_hit(A_SUM_MSK)) sum_msk <= wdata[NG-1:0];
      if (wr_hit(A_G0_MSK))  g0_msk  <= wdata[W0-1:0];
      if (wr_hit(A_G1_MSK))  g1_msk  <= wdata[W1-1:0];
      if (wr_hit(A_G2_MSK))  g2_msk  <= wdata[W2-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:    rdata[0]      = ctrl_en;
      A_TOP_ST:  rdata[0]      = top_st;
      A_TOP_MSK: rdata[1:0]    = top_msk;
      A_SUM:     rdata[NG-1:0] = sum_raw;
      A_SUM_MSK: rdata[NG-1:0] = sum_msk;
      A_G0_ST:   rdata[W0-1:0] = g0_st;
      A_G0_MSK:  rdata[W0-1:0] = g0_msk;
      A_G1_ST:   rdata[W1-1:0] = g1_st;
      A_G1_MSK:  rdata[W1-1:0] = g1_msk;
      A_G2_ST:   rdata[W2-1:0] = g2_st;
      A_G2_MSK:  rdata[W2-1:0] = g2_msk;
      default:   rdata         = '0;
    endcase
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_dev) |=> ((g2_st & $past(ev_dev)) == $past(ev_dev)));

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit(A_G0_ST) && ((wdata[W0-1:0] & ev_ctl) == '0)) |=> ((g0_st & $past(wdata[W0-1:0])) == '0));

  a_r3_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit(A_G1_ST) && wdata[W1-1:0] == '0 && ev_rx == '0) |=> $stable(g1_st));

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit(A_G0_ST) && ((wdata[W0-1:0] & ev_ctl) != '0)) |=> ((g0_st & $past(ev_ctl)) == $past(ev_ctl)));

  a_r6_top_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|sum_pend) |=> top_st);

  a_r8_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !irq_o);
endmodule

// File: tb/usb_irq_tree_tb.sv
module usb_irq_tree_tb;
  localparam int NF = 4;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [5:0] ev_ctl = '0;
  logic [NF-1:0] ev_rx = '0;
  logic [10:0] ev_dev = '0;
  logic irq_o;
  int checks = 0, fails = 0;

  usb_irq_tree #(.NUM_FIFO(NF), .AW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .ev_ctl(ev_ctl), .ev_rx(ev_rx), .ev_dev(ev_dev), .irq_o(irq_o));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 4'(a); wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 4'(a); #1; d = rdata;
  endtask

  task automatic pulse(input int g, input int i);
    @(negedge clk);
    if (g == 0) ev_ctl[i] = 1; else if (g == 1) ev_rx[i] = 1; else ev_dev[i] = 1;
    @(negedge clk); ev_ctl = '0; ev_rx = '0; ev_dev = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int widths[3];
    widths[0] = 6; widths[1] = NF; widths[2] = 11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 top st", v, 0);
    rd(2, v); chk("R1 top msk", v, 3);
    rd(3, v); chk("R1 sum", v, 0);
    rd(4, v); chk("R1 sum msk", v, 7);
    rd(5, v); chk("R1 g0 st", v, 0);
    rd(6, v); chk("R1 g0 msk", v, 32'h3F);
    rd(7, v); chk("R1 g1 st", v, 0);
    rd(8, v); chk("R1 g1 msk", v, 32'hF);
    rd(9, v); chk("R1 g2 st", v, 0);
    rd(10, v); chk("R1 g2 msk", v, 32'h7FF);
    chk("R1 irq", irq_o, 0);

    // R9 register readback, width truncation, read-only summary
    wr(6, 32'hFFFF_FFC0); rd(6, v); chk("R9 g0 msk trunc", v, 0);
    wr(8, 32'h0000_0005); rd(8, v); chk("R9 g1 msk", v, 5);
    wr(8, 0); wr(10, 0); wr(4, 0);
    wr(3, 32'h7); rd(3, v); chk("R9 sum read-only", v, 0);
    wr(2, 32'h2); rd(2, v); chk("R9 top msk", v, 2);
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R9 ctrl", v, 1);

    // R2/R3/R5/R6/R7 sweep over every event bit
    for (int g = 0; g < 3; g++) begin
      for (int i = 0; i < widths[g]; i++) begin
        pulse(g, i);
        rd(5 + 2*g, v); chk("R2 status set", v, 32'(1) << i);
        rd(3, v); chk("R5 summary", v, 32'(1) << g);
        @(negedge clk);
        rd(1, v); chk("R6 top set", v, 1);
        chk("R7 irq high", irq_o, 1);
        wr(5 + 2*g, 0); rd(5 + 2*g, v); chk("R3 zero write", v, 32'(1) << i);
        wr(5 + 2*g, 32'(1) << i); rd(5 + 2*g, v); chk("R3 w1c", v, 0);
        wr(1, 1); rd(1, v); chk("R6 top clear", v, 0);
        chk("R7 irq low", irq_o, 0);
      end
    end

    // R5 all mask patterns of the receive group
    @(negedge clk); ev_rx = '1; @(negedge clk); ev_rx = '0;
    for (int m = 0; m < 16; m++) begin
      wr(8, 32'(m));
      rd(3, v); chk("R5 g1 mask sweep", v, ((4'hF & ~4'(m)) != 0) ? 32'h2 : 32'h0);
    end
    wr(7, 32'hF); wr(8, 0); wr(1, 1);

    // R4 event and clear in the same cycle
    wr(9, 32'h8);
    @(negedge clk); addr = 4'd9; wdata = 32'h8; wr_en = 1; ev_dev = 11'h8;
    @(negedge clk); wr_en = 0; ev_dev = '0; wdata = '0;
    rd(9, v); chk("R4 event wins", v, 32'h8);
    // R6 top clear refused while still pending
    @(negedge clk);
    wr(1, 1); rd(1, v); chk("R6 top held while pending", v, 1);
    // R7 active-low polarity
    wr(2, 0); chk("R7 active low pending", irq_o, 0);
    // R8 enable clear
    wr(0, 0); chk("R8 disabled active low", irq_o, 0);
    wr(2, 2); chk("R8 disabled active high", irq_o, 0);
    wr(0, 1); chk("R7 re-enabled", irq_o, 1);
    wr(9, 32'h8); wr(1, 1);
    wr(2, 0); chk("R7 active low idle", irq_o, 1);
    wr(2, 2);

    // R5 group mask blocks the top level
    wr(4, 32'h4);
    pulse(2, 0);
    @(negedge clk);
    rd(3, v); chk("R5 raw summary", v, 32'h4);
    rd(1, v); chk("R5 group mask blocks top", v, 0);
    chk("R5 irq blocked", irq_o, 0);
    // top mask bit 0 blocks the output
    wr(4, 0); wr(2, 32'h3);
    rd(1, v); chk("R6 top set after unmask", v, 1);
    chk("R7 top masked", irq_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule